// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches the already-synchronized input pins of one GPIO port and turns selected pin activity into pending interrupt flags. For each pin, configuration vectors choose level or edge sensing and the active polarity. A further vector can switch an edge-sensed pin to trigger on both transitions. A flag, once set, stays set until the bus side clears it. To clear flags, the bus side presents a mask together with a one-cycle strobe, and every mask bit at 1 clears its flag. The flag vector is exposed read-only for status polling.

Two combined requests leave the block. The interrupt request is the OR over the pins of each flag gated by its interrupt enable. The wake request is the same reduction gated by the wake enables, for the power manager. A flag is recorded even when both of its enables are off, so software can poll masked pins. In the surrounding register file, the flag status is read at offset 0x40 and the clear mask is written at offset 0x48. The sense-mode, polarity and dual-edge vectors live at 0x28, 0x2C and 0x5C.

Top module: `gpio_irq_detect`

## Requirements
- R1: While `rst` is high at a clock edge, `pend_flags`, `irq_req` and `wake_req` are all 0 after that edge.
- R2: In edge mode (`sense_edge` bit = 1, dual bit = 0), a pin with polarity bit 1 sets its flag on a 0-to-1 change of the pin, and a pin with polarity bit 0 sets it on a 1-to-0 change. The opposite change and an unchanged pin set nothing. An edge is a difference between the pin and its value at the previous clock edge.
- R3: In edge mode with the dual bit = 1, both changes set the flag, whatever the polarity bit.
- R4: In level mode (`sense_edge` bit = 0), the flag is set at every clock edge where the pin equals its polarity bit. The dual bit has no effect.
- R5: A set flag stays 1 after the triggering condition ends until it is cleared. No flag becomes 1 without a detection.
- R6: When `clr_stb` is 1 at a clock edge, every flag whose `clr_mask` bit is 1 becomes 0, and the others are unchanged. When `clr_stb` is 0, `clr_mask` has no effect.
- R7: A detection on a pin in the same cycle as a clear of that pin leaves the flag at 1. A level-mode flag therefore cannot be cleared while its active level persists.
- R8: `irq_req` is registered: one clock after the flags and enables, it equals the OR over all pins of flag AND `irq_en` bit.
- R9: `wake_req` is registered: one clock after the flags and enables, it equals the OR over all pins of flag AND `wake_en` bit.
- R10: Flags are set independently of `irq_en` and `wake_en`.
- R11: The previous-value register loads the pin values during reset, so pins that are already high at reset release do not produce an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| sense_edge | input | NUM_PINS | 1 = edge sensing, 0 = level sensing |
| sense_pol | input | NUM_PINS | 1 = rising/high active, 0 = falling/low active |
| sense_dual | input | NUM_PINS | 1 = both edges in edge mode |
| irq_en | input | NUM_PINS | Interrupt enable per pin |
| wake_en | input | NUM_PINS | Wake enable per pin |
| clr_stb | input | 1 | Clear strobe (write to clear offset) |
| clr_mask | input | NUM_PINS | Write-one-to-clear mask |
| pend_flags | output | NUM_PINS | Pending flags, read-only status |
| irq_req | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Combined wake request |

## Verification
A pin change or a clear is reflected in `pend_flags` at the first clock edge that samples it. `irq_req` and `wake_req` need one more edge after the flags or enables change. The bench drives all inputs on the falling edge. It reads `pend_flags` on the following falling edge, so exactly one rising edge separates stimulus and check. The request outputs are read one falling edge after the enables change. The 32 pins are assigned every combination of mode, polarity, dual bit, start level and end level, so one pass covers the whole sensing table.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;

  // Detection rule for one pin, given current and previous sampled level.
  function automatic logic sense_hit(input sense_e mode, input logic pol,
                                     input logic dual, input logic cur,
                                     input logic prev);
    logic rise;
    logic fall;
    logic hit;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (mode == SENSE_LEVEL) begin
      hit = (cur == pol);
    end else if (dual) begin
      hit = rise | fall;
    end else begin
      hit = pol ? rise : fall;
    end
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_sense.sv
`timescale 1ns/1ps
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] cfg_edge,
  input  logic [NUM_PINS-1:0] cfg_pol,
  input  logic [NUM_PINS-1:0] cfg_dual,
  output logic [NUM_PINS-1:0] hit
);

  logic [NUM_PINS-1:0] prev_q;

  // Previous-value register follows the pins during reset (R11).
  always_ff @(posedge clk) begin
    prev_q <= pin_in;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign hit[g] = sense_hit(sense_e'(cfg_edge[g]), cfg_pol[g], cfg_dual[g],
                              pin_in[g], prev_q[g]);
  end

  // Edge-mode hits need the pin to differ from its last sampled value.
  assert_edge_needs_change_R2: assert property (@(posedge clk) disable iff (rst)
    ((hit & cfg_edge & ~(pin_in ^ $past(pin_in))) == '0));

  // Level-mode pin at the inactive level never hits, dual bit or not.
  assert_level_inactive_R4: assert property (@(posedge clk) disable iff (rst)
    ((hit & ~cfg_edge & (pin_in ^ cfg_pol)) == '0));

endmodule

// File: rtl/gpio_irq_flags.sv
`timescale 1ns/1ps
module gpio_irq_flags #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] hit,
  input  logic                clr_stb,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] flags
);

  logic [NUM_PINS-1:0] clr_eff;
  logic [NUM_PINS-1:0] flags_d;
  logic [NUM_PINS-1:0] flags_q;

  always_comb begin
    clr_eff = clr_stb ? clr_mask : '0;
    flags_d = (flags_q & ~clr_eff) | hit;   // detection wins over clear
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assign flags = flags_q;

  assert_no_spurious_flag_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(hit)) == '0));

  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> ((flags_q & $past(clr_mask) & ~$past(hit)) == '0));

  assert_hit_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((flags_q & $past(hit)) == $past(hit)));

endmodule

// File: rtl/gpio_irq_merge.sv
`timescale 1ns/1ps
module gpio_irq_merge #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] flags,
  input  logic [NUM_PINS-1:0] irq_en,
  input  logic [NUM_PINS-1:0] wake_en,
  output logic                irq_q,
  output logic                wake_q
);

  localparam int NUM_REQ = 2;

  logic [NUM_REQ-1:0][NUM_PINS-1:0] gate;
  logic [NUM_REQ-1:0]               req_d;
  logic [NUM_REQ-1:0]               req_q;

  assign gate[0] = irq_en;
  assign gate[1] = wake_en;

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    assign req_d[r] = |(flags & gate[r]);
    always_ff @(posedge clk) begin
      if (rst) req_q[r] <= 1'b0;
      else     req_q[r] <= req_d[r];
    end
  end

  assign irq_q  = req_q[0];
  assign wake_q = req_q[1];

  assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(|(flags & irq_en)));

  assert_wake_has_source_R9: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> $past(|(flags & wake_en)));

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] sense_edge,
  input  logic [NUM_PINS-1:0] sense_pol,
  input  logic [NUM_PINS-1:0] sense_dual,
  input  logic [NUM_PINS-1:0] irq_en,
  input  logic [NUM_PINS-1:0] wake_en,
  input  logic                clr_stb,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] pend_flags,
  output logic                irq_req,
  output logic                wake_req
);

  logic [NUM_PINS-1:0] hit;

  gpio_irq_sense #(.NUM_PINS(NUM_PINS)) sense_i (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .cfg_edge (sense_edge),
    .cfg_pol  (sense_pol),
    .cfg_dual (sense_dual),
    .hit      (hit)
  );

  gpio_irq_flags #(.NUM_PINS(NUM_PINS)) flags_i (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .clr_stb  (clr_stb),
    .clr_mask (clr_mask),
    .flags    (pend_flags)
  );

  gpio_irq_merge #(.NUM_PINS(NUM_PINS)) merge_i (
    .clk     (clk),
    .rst     (rst),
    .flags   (pend_flags),
    .irq_en  (irq_en),
    .wake_en (wake_en),
    .irq_q   (irq_req),
    .wake_q  (wake_req)
  );

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pend_flags == '0 && !irq_req && !wake_req));

endmodule

// File: tb/gpio_irq_detect_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb_top;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] pin, mode, pol, dual, ien, wen, cmask;
  logic         cstb;
  logic [N-1:0] flags;
  logic         irq, wake;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rst(rst), .pin_in(pin), .sense_edge(mode), .sense_pol(pol),
    .sense_dual(dual), .irq_en(ien), .wake_en(wen), .clr_stb(cstb),
    .clr_mask(cmask), .pend_flags(flags), .irq_req(irq), .wake_req(wake)
  );

  task automatic check(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  logic [N-1:0] exp_f;

  initial begin
    rst = 1'b1; pin = '1; mode = '1; pol = '1; dual = '0;
    ien = '1; wen = '1; cstb = 1'b0; cmask = '0;
    repeat (3) tick();
    // R1: reset state
    check("R1 flags", flags, '0);
    check("R1 irq", {31'd0, irq}, '0);
    check("R1 wake", {31'd0, wake}, '0);
    rst = 1'b0;
    tick(); tick();
    // R11: high pins at release give no rising edge
    check("R11 no edge after reset", flags, '0);
    check("R11 irq stays low", {31'd0, irq}, '0);
    ien = '0; wen = '0;

    // Exhaustive sensing table: pin i -> mode=i[0], pol=i[1], dual=i[2],
    // start level=i[3], end level=i[4].
    for (int i = 0; i < N; i++) begin
      mode[i] = i[0]; pol[i] = i[1]; dual[i] = i[2]; pin[i] = i[3];
      if (i[0]) begin
        if (i[2])      exp_f[i] = (i[3] != i[4]);
        else if (i[1]) exp_f[i] = !i[3] && i[4];
        else           exp_f[i] = i[3] && !i[4];
      end else begin
        exp_f[i] = (i[3] == i[1]) || (i[4] == i[1]);
      end
    end
    tick();
    cstb = 1'b1; cmask = '1;
    tick();
    cstb = 1'b0; cmask = '0;
    for (int i = 0; i < N; i++) pin[i] = i[4];
    tick();
    for (int i = 0; i < N; i++) begin
      string tag;
      if (!i[0])     tag = "R4 level";
      else if (i[2]) tag = "R3 dual edge";
      else           tag = "R2 edge";
      check($sformatf("%s pin %0d", tag, i), {31'd0, flags[i]}, {31'd0, exp_f[i]});
    end
    tick();
    check("R5 flags sticky", flags, exp_f);
    check("R10 flags set with enables off", {31'd0, irq | wake}, '0);

    // R8: one-hot interrupt enable sweep
    for (int k = 0; k < N; k++) begin
      ien = '0; ien[k] = 1'b1;
      tick();
      check($sformatf("R8 irq en %0d", k), {31'd0, irq}, {31'd0, exp_f[k]});
    end
    ien = '0;
    // R9: one-hot wake enable sweep
    for (int k = 0; k < N; k++) begin
      wen = '0; wen[k] = 1'b1;
      tick();
      check($sformatf("R9 wake en %0d", k), {31'd0, wake}, {31'd0, exp_f[k]});
    end
    wen = '0;
    tick();
    check("R8 irq low when all masked", {31'd0, irq}, '0);

    // Write-one-to-clear phase: all pins dual-edge.
    mode = '1; dual = '1; pol = '0; pin = '0;
    tick();
    cstb = 1'b1; cmask = '1;
    tick();
    cstb = 1'b0; cmask = '0; pin = '1;
    tick();
    check("R3 all rising", flags, '1);
    cmask = '1;   // strobe low: mask must be ignored
    tick(); tick();
    check("R6 mask ignored without strobe", flags, '1);
    cstb = 1'b1; cmask = 32'hA5A5_0F0F;
    tick();
    cstb = 1'b0; cmask = '0;
    check("R6 selective clear", flags, ~32'hA5A5_0F0F);
    // R7: edge on pin 4 while clearing pins 4 and 5
    pin[4] = 1'b0; cstb = 1'b1; cmask = 32'h0000_0030;
    tick();
    cstb = 1'b0; cmask = '0;
    check("R7 detection beats clear", {31'd0, flags[4]}, 32'd1);
    check("R6 pin 5 cleared", {31'd0, flags[5]}, 32'd0);
    // R7: level flag survives clear while level held
    mode[8] = 1'b0; pol[8] = 1'b1;
    tick();
    cstb = 1'b1; cmask = 32'h0000_0100;
    tick();
    cstb = 1'b0; cmask = '0;
    check("R7 level clear blocked", {31'd0, flags[8]}, 32'd1);
    pin[8] = 1'b0;
    tick();
    cstb = 1'b1; cmask = 32'h0000_0100;
    tick();
    cstb = 1'b0; cmask = '0;
    check("R7 level clear after release", {31'd0, flags[8]}, 32'd0);
    tick();
    check("R5 no spontaneous set", {31'd0, flags[8]}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule